// File: doc/BRIEF.md
# Gate-List Indirect Access Controller

This block is the register front end of a time-aware transmit gate scheduler. Software never addresses the gate control list memory or the schedule timing registers directly. It first loads a 32-bit word into a staging data register. It then writes an indirect control register that holds three things: an entry index, a target-select bit (list memory or timing registers) and a start bit. A start request commits the staged word to the selected target after a fixed commit latency. During that latency the start bit reads back as a busy flag, which software polls.

A scheduler control register sits beside the indirect pair. It holds a gate enable, a one-cycle switch-list request and a 9-bit time-offset value. The downstream scheduler receives these as outputs. It also gets a registered read port into the list memory and the six timing words: base time low and high, cycle time low and high, time extension, and list length.

A transfer aimed at an index the target does not implement leaves everything unchanged. Instead it raises a sticky error flag that software can read back and clear.

Top module: `gate_list_ctrl`

## Requirements
- R1: After reset, every bus-visible register reads 0: scheduler control at 0x50, indirect control at 0x80 and staging data at 0x84. All six timing outputs are also 0.
- R2: When no transfer is in progress, a write to 0x84 loads the staging data word, and a read of 0x84 returns it.
- R3: A write to 0x80 with bit 0 clear only stages the index (bits 15:8) and the target select (bit 2). No transfer starts. The 0x80 readback shows the index in bits 15:8, the select in bit 2, the sticky error in bit 1 and busy in bit 0. Bits 31:16 and 7:3 read as 0.
- R4: When no transfer is in progress, a write to 0x80 with bit 0 set starts a transfer. Busy (bit 0 of 0x80) then reads 1 for exactly COMMIT_CYC clock cycles after that write edge, and reads 0 from the next cycle on.
- R5: When the select is 0, a completed transfer stores the staged word in list entry `index`. The list read port returns that entry one clock after its index is presented.
- R6: When the select is 1, a completed transfer stores the staged word in the timing word chosen by the index: 0 base-low, 1 base-high, 2 cycle-low, 3 cycle-high, 4 extension, 5 list length.
- R7: While busy is 1, writes to 0x80 and 0x84 are ignored. The staged word, index and select stay as they were, and no second transfer is queued.
- R8: A transfer with a list index at or above LIST_DEPTH, or a timing index above 5, changes no list entry and no timing word. It sets the sticky error flag (bit 1 of 0x80), and later successful transfers do not clear that flag.
- R9: When no transfer is in progress, a write to 0x80 with bit 1 set clears the sticky error flag.
- R10: A write to 0x50 sets the gate enable from bit 0 and the 9-bit time offset from bits 31:23. Both drive the scheduler outputs and read back at the same positions.
- R11: Bit 1 of a 0x50 write produces a switch-list pulse one cycle long. The pulse is high in the cycle after the write edge, shows as bit 1 of the 0x50 readback only in that cycle, and then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sched_en | output | 1 | Gate scheduler enable |
| sched_switch | output | 1 | One-cycle switch-list request |
| sched_offset | output | 9 | Time-offset value |
| gl_rd_idx | input | LIST_AW | List read-port index |
| gl_rd_data | output | 32 | List entry at gl_rd_idx, one cycle later |
| tm_base_lo | output | 32 | Base time, low word |
| tm_base_hi | output | 32 | Base time, high word |
| tm_cycle_lo | output | 32 | Cycle time, low word |
| tm_cycle_hi | output | 32 | Cycle time, high word |
| tm_ext | output | 32 | Time extension |
| tm_list_len | output | 32 | List length |

## Verification
The hardest state to reach from the ports is the busy window with conflicting traffic arriving inside it. The bench starts a transfer and then issues back-to-back writes to the data register and to the control register while the commit is still pending. One of those control writes carries a fresh start bit, a different index and the other select. The bench then shows that the entry that landed, the staged word and the staged index all come from before the window. The error path is reached with index 64, which aliases to list entry 0 in the address bits. The bench then confirms that entry 0 still holds its earlier value.

// File: rtl/gl_pkg.sv
package gl_pkg;
  // Register width of the bus and of every stored word
  localparam int REG_W = 32;
  // Byte offsets on the register bus
  localparam int OFS_SCHED = 'h50;
  localparam int OFS_CTRL  = 'h80;
  localparam int OFS_DATA  = 'h84;
  // Indirect control field positions
  localparam int CB_START = 0;
  localparam int CB_ERR   = 1;
  localparam int CB_SEL   = 2;
  localparam int IDX_LSB  = 8;
  localparam int IDX_W    = 8;
  // Scheduler control field positions
  localparam int SB_EN    = 0;
  localparam int SB_SW    = 1;
  localparam int OFFS_LSB = 23;
  localparam int OFFS_W   = 9;
  // Timing word indices
  typedef enum logic [IDX_W-1:0] {
    TM_BASE_LO  = 8'd0,
    TM_BASE_HI  = 8'd1,
    TM_CYCLE_LO = 8'd2,
    TM_CYCLE_HI = 8'd3,
    TM_EXT      = 8'd4,
    TM_LEN      = 8'd5
  } tm_idx_e;
  localparam int TM_COUNT = 6;
endpackage

// File: rtl/gl_commit_engine.sv
module gl_commit_engine #(
  parameter int COMMIT_CYC = 4,
  localparam int CW = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = CW'(COMMIT_CYC - 1);
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy   = busy_q;
  assign commit = busy_q && (cnt_q == '0);
endmodule

// File: rtl/gl_list_ram.sv
module gl_list_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[ridx];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/gl_timing_bank.sv
module gl_timing_bank #(
  parameter int N  = 6,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][DW-1:0] words
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic          en;
    logic [DW-1:0] q;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign words[g] = q;
  end
endmodule

// File: rtl/gate_list_ctrl.sv
module gate_list_ctrl import gl_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int LIST_DEPTH = 64,
  parameter int COMMIT_CYC = 4,
  localparam int LIST_AW   = $clog2(LIST_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               sched_en,
  output logic               sched_switch,
  output logic [OFFS_W-1:0]  sched_offset,
  input  logic [LIST_AW-1:0] gl_rd_idx,
  output logic [REG_W-1:0]   gl_rd_data,
  output logic [REG_W-1:0]   tm_base_lo,
  output logic [REG_W-1:0]   tm_base_hi,
  output logic [REG_W-1:0]   tm_cycle_lo,
  output logic [REG_W-1:0]   tm_cycle_hi,
  output logic [REG_W-1:0]   tm_ext,
  output logic [REG_W-1:0]   tm_list_len
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  // Bus decode
  logic wr_sched, wr_ctrl, wr_data;
  assign wr_sched = reg_wr && (reg_addr == ADDR_W'(OFS_SCHED));
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_data  = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));

  logic busy, commit, start;
  assign start = wr_ctrl && !busy && reg_wdata[CB_START];

  gl_commit_engine #(.COMMIT_CYC(COMMIT_CYC)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (start),
    .busy   (busy),
    .commit (commit)
  );

  // Staging state
  logic [REG_W-1:0] stg_data_q, stg_data_d;
  logic [IDX_W-1:0] stg_idx_q, stg_idx_d;
  logic             stg_sel_q, stg_sel_d;
  logic             err_q, err_d;
  logic             bad_idx;

  assign bad_idx = stg_sel_q ? (int'(stg_idx_q) >= TM_COUNT)
                             : (int'(stg_idx_q) >= LIST_DEPTH);

  always_comb begin
    stg_data_d = stg_data_q;
    stg_idx_d  = stg_idx_q;
    stg_sel_d  = stg_sel_q;
    err_d      = err_q;
    if (wr_data && !busy) stg_data_d = reg_wdata;
    if (wr_ctrl && !busy) begin
      stg_idx_d = reg_wdata[IDX_LSB +: IDX_W];
      stg_sel_d = reg_wdata[CB_SEL];
      if (reg_wdata[CB_ERR]) err_d = 1'b0;
    end
    if (commit && bad_idx) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stg_data_q <= '0;
      stg_idx_q  <= '0;
      stg_sel_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      stg_data_q <= stg_data_d;
      stg_idx_q  <= stg_idx_d;
      stg_sel_q  <= stg_sel_d;
      err_q      <= err_d;
    end
  end

  // Commit steering
  logic ram_we, tm_we;
  assign ram_we = commit && !stg_sel_q && !bad_idx;
  assign tm_we  = commit &&  stg_sel_q && !bad_idx;

  gl_list_ram #(.DEPTH(LIST_DEPTH), .DW(REG_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (ram_we),
    .widx  (stg_idx_q[LIST_AW-1:0]),
    .wdata (stg_data_q),
    .ridx  (gl_rd_idx),
    .rdata (gl_rd_data)
  );

  logic [TM_COUNT-1:0][REG_W-1:0] tm_words;

  gl_timing_bank #(.N(TM_COUNT), .DW(REG_W), .IW(IDX_W)) u_tm (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (tm_we),
    .widx  (stg_idx_q),
    .wdata (stg_data_q),
    .words (tm_words)
  );

  assign tm_base_lo  = tm_words[TM_BASE_LO];
  assign tm_base_hi  = tm_words[TM_BASE_HI];
  assign tm_cycle_lo = tm_words[TM_CYCLE_LO];
  assign tm_cycle_hi = tm_words[TM_CYCLE_HI];
  assign tm_ext      = tm_words[TM_EXT];
  assign tm_list_len = tm_words[TM_LEN];

  // Scheduler control
  logic              en_q, en_d, sw_q, sw_d;
  logic [OFFS_W-1:0] offs_q, offs_d;

  always_comb begin
    en_d   = en_q;
    offs_d = offs_q;
    sw_d   = 1'b0;
    if (wr_sched) begin
      en_d   = reg_wdata[SB_EN];
      offs_d = reg_wdata[OFFS_LSB +: OFFS_W];
      sw_d   = reg_wdata[SB_SW];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= 1'b0;
      sw_q   <= 1'b0;
      offs_q <= '0;
    end else begin
      en_q   <= en_d;
      sw_q   <= sw_d;
      offs_q <= offs_d;
    end
  end

  assign sched_en     = en_q;
  assign sched_switch = sw_q;
  assign sched_offset = offs_q;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_SCHED)) begin
      reg_rdata[OFFS_LSB +: OFFS_W] = offs_q;
      reg_rdata[SB_SW]              = sw_q;
      reg_rdata[SB_EN]              = en_q;
    end else if (reg_addr == ADDR_W'(OFS_CTRL)) begin
      reg_rdata[IDX_LSB +: IDX_W] = stg_idx_q;
      reg_rdata[CB_SEL]           = stg_sel_q;
      reg_rdata[CB_ERR]           = err_q;
      reg_rdata[CB_START]         = busy;
    end else if (reg_addr == ADDR_W'(OFS_DATA)) begin
      reg_rdata = stg_data_q;
    end
  end
endmodule

// File: rtl/gl_ctrl_chk.sv
module gl_ctrl_chk import gl_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int COMMIT_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              busy,
  input logic              err,
  input logic [REG_W-1:0]  stg_data,
  input logic              sched_switch
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  logic ctrl_wr, data_wr, sched_wr;
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign data_wr  = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));
  assign sched_wr = reg_wr && (reg_addr == ADDR_W'(OFS_SCHED));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[CB_START] && !busy |=> busy);
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == 32'(COMMIT_CYC));
  // R4
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < 32'(COMMIT_CYC));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_wr |=> $stable(stg_data));
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(ctrl_wr && reg_wdata[CB_ERR] && !busy));
  // R11
  sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_switch |=> !sched_switch);
  // R11
  sw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sched_switch) |-> $past(sched_wr && reg_wdata[SB_SW]));
endmodule

bind gate_list_ctrl gl_ctrl_chk #(.ADDR_W(ADDR_W), .COMMIT_CYC(COMMIT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .busy         (busy),
  .err          (err_q),
  .stg_data     (stg_data_q),
  .sched_switch (sched_switch)
);

// File: tb/sim_gate_list_ctrl.sv
module sim_gate_list_ctrl;
  localparam int AW    = 12;
  localparam int DEPTH = 64;
  localparam int CC    = 4;
  localparam int LAW   = $clog2(DEPTH);
  localparam logic [AW-1:0] A_SCHED = 12'h050;
  localparam logic [AW-1:0] A_CTRL  = 12'h080;
  localparam logic [AW-1:0] A_DATA  = 12'h084;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, reg_wr;
  logic [AW-1:0]  reg_addr;
  logic [31:0]    reg_wdata, reg_rdata, gl_rd_data;
  logic           sched_en, sched_switch;
  logic [8:0]     sched_offset;
  logic [LAW-1:0] gl_rd_idx;
  logic [31:0]    tm_base_lo, tm_base_hi, tm_cycle_lo, tm_cycle_hi, tm_ext, tm_list_len;

  gate_list_ctrl #(.ADDR_W(AW), .LIST_DEPTH(DEPTH), .COMMIT_CYC(CC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sched_en(sched_en),
    .sched_switch(sched_switch), .sched_offset(sched_offset),
    .gl_rd_idx(gl_rd_idx), .gl_rd_data(gl_rd_data),
    .tm_base_lo(tm_base_lo), .tm_base_hi(tm_base_hi),
    .tm_cycle_lo(tm_cycle_lo), .tm_cycle_hi(tm_cycle_hi),
    .tm_ext(tm_ext), .tm_list_len(tm_list_len));

  // Scoreboard: kind 0 bus read, 1 list port, 2 timing word sel, 3 scheduler outputs
  typedef struct {
    string       req;
    int          kind;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  pushed;
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] observe(int kind, int sel);
    case (kind)
      0: return reg_rdata;
      1: return gl_rd_data;
      2: case (sel)
           0: return tm_base_lo;
           1: return tm_base_hi;
           2: return tm_cycle_lo;
           3: return tm_cycle_hi;
           4: return tm_ext;
           default: return tm_list_len;
         endcase
      default: return {sched_offset, 21'b0, sched_switch, sched_en};
    endcase
  endfunction

  initial begin
    forever begin
      @(pushed);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = q.pop_front();
        got = observe(it.kind, it.sel);
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d sel=%0d got=%h exp=%h", it.req, it.kind, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, int sel, logic [31:0] exp, string req);
    item_t it;
    it.req = req; it.kind = kind; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> pushed;
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_bus_now(logic [AW-1:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1 push(0, 0, exp, req);
  endtask

  task automatic chk_bus(logic [AW-1:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    chk_bus_now(a, exp, req);
  endtask

  task automatic chk_list(int idx, logic [31:0] exp, string req);
    @(negedge clk);
    gl_rd_idx = LAW'(idx);
    @(negedge clk);
    #1 push(1, 0, exp, req);
  endtask

  task automatic chk_tm(int i, logic [31:0] exp, string req);
    @(negedge clk);
    #1 push(2, i, exp, req);
  endtask

  task automatic chk_sched_now(logic [31:0] exp, string req);
    #1 push(3, 0, exp, req);
  endtask

  task automatic wait_idle();
    reg_addr = A_CTRL;
    #1;
    while (reg_rdata[0]) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic ind_write(bit sel, int idx, logic [31:0] d);
    bus_wr(A_DATA, d);
    bus_wr(A_CTRL, (32'(idx) << 8) | (32'(sel) << 2) | 32'h1);
    wait_idle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  logic [31:0] offs;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; gl_rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    chk_bus(A_CTRL, 32'h0, "R1");
    chk_bus(A_DATA, 32'h0, "R1");
    chk_bus(A_SCHED, 32'h0, "R1");
    for (int i = 0; i < 6; i++) chk_tm(i, 32'h0, "R1");

    // R2: data register
    bus_wr(A_DATA, 32'hA5A5_1234);
    chk_bus(A_DATA, 32'hA5A5_1234, "R2");

    // R3: stage only, no transfer, no error
    bus_wr(A_CTRL, 32'h0000_2A04);
    chk_bus(A_CTRL, 32'h0000_2A04, "R3");
    bus_wr(A_CTRL, 32'h0000_0204);
    chk_bus(A_CTRL, 32'h0000_0204, "R3");
    chk_tm(2, 32'h0, "R3");

    // R4: busy for exactly CC cycles
    bus_wr(A_DATA, 32'hCAFE_0005);
    bus_wr(A_CTRL, 32'h0000_0501);
    chk_bus_now(A_CTRL, 32'h0000_0501, "R4");
    for (int k = 1; k < CC; k++) begin
      @(negedge clk);
      chk_bus_now(A_CTRL, 32'h0000_0501, "R4");
    end
    @(negedge clk);
    chk_bus_now(A_CTRL, 32'h0000_0500, "R4");
    // R5: list write lands
    chk_list(5, 32'hCAFE_0005, "R5");
    ind_write(1'b0, 0, 32'h1111_0000);
    ind_write(1'b0, 63, 32'h3F3F_3F3F);
    chk_list(0, 32'h1111_0000, "R5");
    chk_list(63, 32'h3F3F_3F3F, "R5");

    // R6: timing words
    for (int i = 0; i < 6; i++) ind_write(1'b1, i, 32'h7000_0000 + 32'(i) * 32'h0101);
    for (int i = 0; i < 6; i++) chk_tm(i, 32'h7000_0000 + 32'(i) * 32'h0101, "R6");

    // R7: writes during busy are ignored
    bus_wr(A_DATA, 32'h0BAD_0001);
    bus_wr(A_CTRL, 32'h0000_0A01);
    bus_wr(A_DATA, 32'hDEAD_BEEF);
    bus_wr(A_CTRL, 32'h0000_0105);
    wait_idle();
    chk_bus(A_DATA, 32'h0BAD_0001, "R7");
    chk_bus(A_CTRL, 32'h0000_0A00, "R7");
    chk_list(10, 32'h0BAD_0001, "R7");
    chk_tm(1, 32'h7000_0101, "R7");

    // R8: out-of-range index
    ind_write(1'b0, 64, 32'h5555_5555);
    chk_bus(A_CTRL, 32'h0000_4002, "R8");
    chk_list(0, 32'h1111_0000, "R8");
    ind_write(1'b1, 6, 32'h6666_6666);
    chk_bus(A_CTRL, 32'h0000_0606, "R8");
    for (int i = 0; i < 6; i++) chk_tm(i, 32'h7000_0000 + 32'(i) * 32'h0101, "R8");
    ind_write(1'b0, 1, 32'h0000_0101);
    chk_bus(A_CTRL, 32'h0000_0102, "R8");
    chk_list(1, 32'h0000_0101, "R5");

    // R9: clear the sticky error
    bus_wr(A_CTRL, 32'h0000_0102);
    chk_bus(A_CTRL, 32'h0000_0100, "R9");

    // R10: enable and offset
    offs = 32'(9'h1A5) << 23;
    bus_wr(A_SCHED, offs | 32'h1);
    chk_sched_now(offs | 32'h1, "R10");
    chk_bus(A_SCHED, offs | 32'h1, "R10");

    // R11: switch pulse lasts one cycle
    bus_wr(A_SCHED, offs | 32'h3);
    chk_sched_now(offs | 32'h3, "R11");
    chk_bus_now(A_SCHED, offs | 32'h3, "R11");
    @(negedge clk);
    chk_sched_now(offs | 32'h1, "R11");
    chk_bus_now(A_SCHED, offs | 32'h1, "R11");

    // R10: disable
    bus_wr(A_SCHED, 32'h0);
    chk_sched_now(32'h0, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule